// File: doc/BRIEF.md
# HMAC Phase Sequencer

This block steers an external hash core through the rounds of a keyed-hash (HMAC) computation. It can also run a plain hash. The sequencer owns only the control flow and the key transform. It decides which phase the host is in. It tells the host when input is accepted. It widens the key with zero words to one full data block, and it XORs each key word with the inner pad byte 0x36 or the outer pad byte 0x5C, replicated over the word. Message words go straight from the host to the core, so the sequencer only watches the final strobe that closes each input stream. Compression, message padding and input buffering belong to the core.

An HMAC run has four phases that the host can see: setup, inner key, message, outer key. The host supplies the key twice. The inner hash digest stays inside the core, which uses it as the message of the outer hash. The final result is flagged only after the outer round has completed. A long key is one that is longer than a block. When the key type says long, the key is hashed first. The core then returns that digest word by word, and the digest is padded and transformed in place of the raw key.

Top module: `hmac_phase_seq`

## Requirements
- R1: After synchronous reset, `phase` is 0 (setup), `ready` is 1, and `kx_valid`, `core_fin` and `digest_valid` are 0.
- R2: A cycle with `init` high restarts the sequence. The phase codes are 0 setup, 1 inner key, 2 message, 3 outer key. With `mode_hmac`=1 the next phase is 1; with `mode_hmac`=0 it is 2.
- R3: For a short key, every accepted key word appears on `kx_data` with `kx_valid` high one cycle after it was accepted. The word is XORed with 32'h36363636 in phase 1 and with 32'h5C5C5C5C in phase 3.
- R4: A key block always holds exactly BLK_WORDS words. After `fin`, the sequencer emits one pad word per cycle (zero XOR pad) until the block is complete. Short-key words beyond BLK_WORDS are dropped.
- R5: For a long key (`key_long`=1 in HMAC mode), key words pass through untransformed. `fin` pulses `core_fin` and drops `ready`. After `core_done`, the sequencer takes DIG_WORDS words on `dg_data`, outputs each one XORed with the pad, and then pads the block with pad words.
- R6: In the message phase, `fin` pulses `core_fin` for one cycle and `ready` stays low until `core_done` arrives. A `core_done` that arrives before `fin` has no effect.
- R7: In HMAC mode, `core_done` after the message moves to phase 3 with `ready` high, and no word of the inner digest appears on `kx_data`.
- R8: Completing the outer key block pulses `core_fin`. The following `core_done` raises `digest_valid`, with `ready` low and phase 3, and both hold until the next `init`.
- R9: In plain mode, `key_long` is ignored and key words are never transformed. The message `fin` and then `core_done` lead directly to `digest_valid`, with one `core_fin` pulse in total.
- R10: `init` taken in the middle of a key phase abandons that phase and enters the newly selected phase on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Start a new computation, sampling the mode and key type |
| mode_hmac | input | 1 | 1: keyed hash, 0: plain hash |
| key_long | input | 1 | 1: key is hashed first (HMAC only) |
| din_valid | input | 1 | Host key word valid |
| din_data | input | WORD_W | Host key word |
| fin | input | 1 | Closes the current host input stream |
| core_done | input | 1 | Core finished its current round |
| dg_valid | input | 1 | Core returns a hashed-key digest word |
| dg_data | input | WORD_W | Hashed-key digest word |
| phase | output | 2 | Host-visible phase code |
| ready | output | 1 | Host input accepted in the current phase |
| kx_valid | output | 1 | Transformed key word valid toward the core |
| kx_data | output | WORD_W | Transformed key word |
| core_fin | output | 1 | One-cycle request for the core to finalize the round |
| digest_valid | output | 1 | HMAC or plain digest can be read from the core |

## Verification
The bench builds the block with its default parameters: 32-bit words, 16-word blocks and a 5-word hashed-key digest. A block that small lets the bench sweep every short-key length from 0 to 16 words, plus two lengths that overflow the block. Each length runs through both the inner and the outer round, and every word is compared with a value computed arithmetically in the bench. The same setup also covers a long-key run with digest return, a plain run with the key type set, and a restart in the middle of a key phase.

// File: rtl/hmac_seq_pkg.sv
package hmac_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_KEY,
        S_KHASH,
        S_KDIG,
        S_ZFILL,
        S_MSG,
        S_RUN,
        S_DONE
    } seq_state_t;

    localparam logic [1:0] PH_SETUP = 2'd0;
    localparam logic [1:0] PH_INNER = 2'd1;
    localparam logic [1:0] PH_MSG   = 2'd2;
    localparam logic [1:0] PH_OUTER = 2'd3;

    localparam logic [7:0] PAD_IN_BYTE  = 8'h36;
    localparam logic [7:0] PAD_OUT_BYTE = 8'h5C;

    function automatic logic [7:0] pad_byte(input logic outer);
        return outer ? PAD_OUT_BYTE : PAD_IN_BYTE;
    endfunction

endpackage

// File: rtl/hmac_pad_xor.sv
module hmac_pad_xor
    import hmac_seq_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              outer,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] word_mixed,
    output logic [WORD_W-1:0] pad_word
);
    localparam int NBYTES = WORD_W / 8;

    logic [7:0] pb;
    assign pb = pad_byte(outer);

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign pad_word[b*8 +: 8]   = pb;
        assign word_mixed[b*8 +: 8] = word_in[b*8 +: 8] ^ pb;
    end
endmodule

// File: rtl/hmac_phase_map.sv
module hmac_phase_map
    import hmac_seq_pkg::*;
(
    input  seq_state_t state,
    input  logic       outer,
    output logic [1:0] phase,
    output logic       ready
);
    always_comb begin
        unique case (state)
            S_IDLE:                        phase = PH_SETUP;
            S_KEY, S_KHASH, S_KDIG, S_ZFILL: phase = outer ? PH_OUTER : PH_INNER;
            S_MSG:                         phase = PH_MSG;
            default:                       phase = outer ? PH_OUTER : PH_MSG;
        endcase
        ready = (state == S_IDLE) || (state == S_KEY) || (state == S_MSG);
    end
endmodule

// File: rtl/hmac_phase_seq.sv
module hmac_phase_seq
    import hmac_seq_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 16,
    parameter int DIG_WORDS = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              mode_hmac,
    input  logic              key_long,
    input  logic              din_valid,
    input  logic [WORD_W-1:0] din_data,
    input  logic              fin,
    input  logic              core_done,
    input  logic              dg_valid,
    input  logic [WORD_W-1:0] dg_data,
    output logic [1:0]        phase,
    output logic              ready,
    output logic              kx_valid,
    output logic [WORD_W-1:0] kx_data,
    output logic              core_fin,
    output logic              digest_valid
);
    localparam int CNT_W = $clog2(BLK_WORDS + 1);
    localparam logic [CNT_W-1:0] BLK_C     = CNT_W'(BLK_WORDS);
    localparam logic [CNT_W-1:0] BLK_LAST  = CNT_W'(BLK_WORDS - 1);
    localparam logic [CNT_W-1:0] DIG_LAST  = CNT_W'(DIG_WORDS - 1);

    seq_state_t       state;
    logic             hmac_q, long_q, outer_q;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             take;
    logic [WORD_W-1:0] mix_src, mixed, pad_w;

    assign mix_src = (state == S_KDIG) ? dg_data : din_data;

    hmac_pad_xor #(.WORD_W(WORD_W)) u_pad (
        .outer      (outer_q),
        .word_in    (mix_src),
        .word_mixed (mixed),
        .pad_word   (pad_w)
    );

    hmac_phase_map u_map (
        .state (state),
        .outer (outer_q),
        .phase (phase),
        .ready (ready)
    );

    always_comb begin
        take  = din_valid && (long_q || (cnt < BLK_C));
        cnt_n = cnt + CNT_W'(take && !long_q);
    end

    assign digest_valid = (state == S_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            hmac_q   <= 1'b0;
            long_q   <= 1'b0;
            outer_q  <= 1'b0;
            cnt      <= '0;
            kx_valid <= 1'b0;
            kx_data  <= '0;
            core_fin <= 1'b0;
        end else begin
            kx_valid <= 1'b0;
            core_fin <= 1'b0;
            if (init) begin
                state   <= mode_hmac ? S_KEY : S_MSG;
                hmac_q  <= mode_hmac;
                long_q  <= mode_hmac & key_long;
                outer_q <= 1'b0;
                cnt     <= '0;
            end else begin
                unique case (state)
                    S_KEY: begin
                        if (take) begin
                            kx_valid <= 1'b1;
                            kx_data  <= long_q ? din_data : mixed;
                        end
                        cnt <= cnt_n;
                        if (fin) begin
                            if (long_q) begin
                                core_fin <= 1'b1;
                                state    <= S_KHASH;
                            end else if (cnt_n == BLK_C) begin
                                if (outer_q) begin
                                    core_fin <= 1'b1;
                                    state    <= S_RUN;
                                end else begin
                                    state <= S_MSG;
                                end
                            end else begin
                                state <= S_ZFILL;
                            end
                        end
                    end
                    S_KHASH: begin
                        if (core_done) begin
                            cnt   <= '0;
                            state <= S_KDIG;
                        end
                    end
                    S_KDIG: begin
                        if (dg_valid) begin
                            kx_valid <= 1'b1;
                            kx_data  <= mixed;
                            cnt      <= cnt + 1'b1;
                            if (cnt == DIG_LAST) state <= S_ZFILL;
                        end
                    end
                    S_ZFILL: begin
                        kx_valid <= 1'b1;
                        kx_data  <= pad_w;
                        cnt      <= cnt + 1'b1;
                        if (cnt == BLK_LAST) begin
                            if (outer_q) begin
                                core_fin <= 1'b1;
                                state    <= S_RUN;
                            end else begin
                                state <= S_MSG;
                            end
                        end
                    end
                    S_MSG: begin
                        if (fin) begin
                            core_fin <= 1'b1;
                            state    <= S_RUN;
                        end
                    end
                    S_RUN: begin
                        if (core_done) begin
                            if (hmac_q && !outer_q) begin
                                outer_q <= 1'b1;
                                cnt     <= '0;
                                state   <= S_KEY;
                            end else begin
                                state <= S_DONE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R3: a transformed word only ever leaves during a key phase
    a_r3_kx_in_key_phase: assert property (@(posedge clk) disable iff (rst)
        kx_valid |-> ($past(phase) == PH_INNER || $past(phase) == PH_OUTER));

    // R6: finalize request is a single-cycle pulse
    a_r6_fin_single: assert property (@(posedge clk) disable iff (rst)
        core_fin |=> !core_fin);

    // R8: the result flag only rises after the core reports completion
    a_r8_done_after_core: assert property (@(posedge clk) disable iff (rst)
        $rose(digest_valid) |-> $past(core_done));

    // R8: no host input is taken once the result is flagged
    a_r8_done_not_ready: assert property (@(posedge clk) disable iff (rst)
        digest_valid |-> !ready);

    // R7: the outer key phase is entered only from the message round
    a_r7_outer_from_msg: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_OUTER && $past(phase) != PH_OUTER) |-> $past(phase) == PH_MSG);

    // R4: no key block grows past its size
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        $past(cnt) == BLK_C |-> !kx_valid || $past(long_q) || $past(state) == S_KEY && $past(long_q));

endmodule

// File: tb/hmac_phase_seq_tb_top.sv
`timescale 1ns/1ps
module hmac_phase_seq_tb_top;
    localparam int W   = 32;
    localparam int BLK = 16;
    localparam int DIG = 5;
    localparam logic [31:0] P_IN  = 32'h36363636;
    localparam logic [31:0] P_OUT = 32'h5C5C5C5C;

    logic clk = 1'b0;
    logic rst, init, mode_hmac, key_long, din_valid, fin, core_done, dg_valid;
    logic [W-1:0] din_data, dg_data, kx_data;
    logic [1:0] phase;
    logic ready, kx_valid, core_fin, digest_valid;

    always #2.5 clk = ~clk;

    hmac_phase_seq dut_i (
        .clk(clk), .rst(rst), .init(init), .mode_hmac(mode_hmac), .key_long(key_long),
        .din_valid(din_valid), .din_data(din_data), .fin(fin), .core_done(core_done),
        .dg_valid(dg_valid), .dg_data(dg_data), .phase(phase), .ready(ready),
        .kx_valid(kx_valid), .kx_data(kx_data), .core_fin(core_fin),
        .digest_valid(digest_valid)
    );

    int vecs = 0, errs = 0;
    int exp_n = 0, got_n = 0, fin_cnt = 0;
    logic [31:0] exp_q [0:63];
    bit finished = 0;

    function automatic logic [31:0] kw(input int i);
        return 32'h9E3779B9 * (i + 1) + 32'h1234;
    endfunction
    function automatic logic [31:0] dw(input int j);
        return 32'hD1E50000 | j;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && kx_valid) begin
            if (got_n < exp_n)
                check(kx_data == exp_q[got_n], "R3/R4/R5 key word", kx_data, exp_q[got_n]);
            else
                check(1'b0, "R4/R7 unexpected key word", kx_data, 32'h0);
            got_n++;
        end
        if (!rst && core_fin) fin_cnt++;
    end

    task automatic tick; @(posedge clk); #1; endtask

    task automatic do_init(input logic m, input logic l);
        mode_hmac = m; key_long = l; init = 1'b1; tick; init = 1'b0;
    endtask
    task automatic send_words(input int n);
        for (int i = 0; i < n; i++) begin
            din_valid = 1'b1; din_data = kw(i); tick;
        end
        din_valid = 1'b0;
    endtask
    task automatic pulse_fin; fin = 1'b1; tick; fin = 1'b0; endtask
    task automatic pulse_done; core_done = 1'b1; tick; core_done = 1'b0; endtask

    task automatic key_phase(input bit lng, input int n, input logic [31:0] pad);
        int k;
        got_n = 0; k = 0;
        if (lng) begin
            for (int i = 0; i < n; i++) begin exp_q[k] = kw(i); k++; end
            for (int j = 0; j < DIG; j++) begin exp_q[k] = dw(j) ^ pad; k++; end
            for (int j = DIG; j < BLK; j++) begin exp_q[k] = pad; k++; end
        end else begin
            for (int i = 0; i < BLK; i++) begin
                exp_q[k] = (i < n) ? (kw(i) ^ pad) : pad; k++;
            end
        end
        exp_n = k;
        send_words(n);
        pulse_fin;
        if (lng) begin
            tick;
            check(ready == 1'b0, "R5 not ready during key hash", {31'b0, ready}, 32'h0);
            pulse_done;
            for (int j = 0; j < DIG; j++) begin
                dg_valid = 1'b1; dg_data = dw(j); tick;
            end
            dg_valid = 1'b0;
        end
        for (int t = 0; t < 100 && got_n < exp_n; t++) tick;
        tick;
        check(got_n == exp_n, "R4 block word count", got_n, exp_n);
    endtask

    task automatic hmac_run(input bit lng, input int n);
        int f0;
        f0 = fin_cnt;
        do_init(1'b1, lng);
        check(phase == 2'd1, "R2 hmac enters inner key", phase, 32'd1);
        key_phase(lng, n, P_IN);
        check(phase == 2'd2 && ready, "R4 message phase after inner key", {ready, phase}, 32'h6);
        got_n = 0; exp_n = 0;
        pulse_done;
        check(phase == 2'd2 && ready, "R6 early core_done ignored", {ready, phase}, 32'h6);
        send_words(3);
        pulse_fin;
        check(phase == 2'd2 && !ready, "R6 waiting for inner round", {ready, phase}, 32'h2);
        pulse_done;
        tick;
        check(phase == 2'd3 && ready && !digest_valid, "R7 outer key phase",
              {digest_valid, ready, phase}, 32'h7);
        check(got_n == 0, "R7 inner digest hidden", got_n, 0);
        key_phase(lng, n, P_OUT);
        check(!ready && !digest_valid && phase == 2'd3, "R8 outer round running",
              {digest_valid, ready, phase}, 32'h3);
        pulse_done;
        check(digest_valid && !ready && phase == 2'd3, "R8 result flagged",
              {digest_valid, ready, phase}, 32'hB);
        tick; tick;
        check(digest_valid, "R8 result held", {31'b0, digest_valid}, 32'h1);
        check(fin_cnt - f0 == (lng ? 4 : 2), "R5/R8 finalize pulses", fin_cnt - f0, lng ? 4 : 2);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            errs++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; init = 1'b0; mode_hmac = 1'b0; key_long = 1'b0; din_valid = 1'b0;
        fin = 1'b0; core_done = 1'b0; dg_valid = 1'b0; din_data = '0; dg_data = '0;
        tick; tick; tick;
        rst = 1'b0;
        check(phase == 2'd0 && ready && !kx_valid && !core_fin && !digest_valid,
              "R1 reset state", {kx_valid, core_fin, digest_valid, ready, phase}, 32'h4);

        // R3 R4: sweep short key lengths including overflow of the block
        for (int n = 0; n <= BLK + 2; n++) hmac_run(1'b0, n);
        // R5: long key hashed first
        hmac_run(1'b1, 20);

        // R9: plain mode ignores key type
        begin
            int f0;
            f0 = fin_cnt; got_n = 0; exp_n = 0;
            do_init(1'b0, 1'b1);
            check(phase == 2'd2 && ready, "R9 plain skips key phases", {ready, phase}, 32'h6);
            send_words(4);
            pulse_fin;
            pulse_done;
            check(digest_valid && phase == 2'd2, "R9 plain result", {digest_valid, phase}, 32'h6);
            tick;
            check(got_n == 0, "R9 no key words in plain mode", got_n, 0);
            check(fin_cnt - f0 == 1, "R9 one finalize pulse", fin_cnt - f0, 1);
        end

        // R10: restart in the middle of a key phase
        got_n = 0; exp_n = 3;
        for (int i = 0; i < 3; i++) exp_q[i] = kw(i) ^ P_IN;
        do_init(1'b1, 1'b0);
        send_words(3);
        do_init(1'b0, 1'b0);
        check(phase == 2'd2 && ready, "R10 restart to message", {ready, phase}, 32'h6);
        tick; tick;
        check(got_n == 3, "R10 no fill after restart", got_n, 3);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule